// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM

A clocked, single-port static memory model with separate write-data and read-data buses. An access begins when the start strobe is sampled high on a rising clock edge. The write-enable, address and write data are sampled on that same edge. A write stores one word on that edge. A read sets up an internal location counter and then delivers data words on the read bus, each marked by a valid flag.

A read is either a single access that returns one word, or a burst that returns four words from one aligned four-word block. In a burst, the host presents the address once and the internal counter steps through the block. The advance input lets the host pause the stream between beats. A new start strobe abandons whatever the previous burst had not yet fetched.

The first word of a read leaves the block two clocks after the address edge, and each further burst word follows one clock later. The burst therefore runs on a 2-1-1-1 schedule: four words in five clocks, where four single reads need eight.

Top module: `burstSram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dataValid` is low.
- R2: A start edge with `writeEn` high stores `dataIn` at `addr` on that edge. A read of the same address started on the very next edge returns the new word.
- R3: A burst read (start edge n, `writeEn` low, `burstMode` high, `advance` high) presents its first word with `dataValid` high in the cycle after edge n+2. The remaining three words follow after edges n+3, n+4 and n+5, so the burst spans five clocks.
- R4: Burst word k (k = 0..3) comes from address {addr[AW-1:2], (addr[1:0]+k) mod 4}. Only the two low address bits count, and they wrap inside the aligned four-word block.
- R5: A single read (`burstMode` low) returns exactly one word, from `addr`, after edge n+2. Single reads can be started every second edge, so each one costs two clocks.
- R6: A read word is fetched only on an edge where `advance` is high. Each edge with `advance` low leaves `dataValid` low one cycle later and leaves the counter where it was. The next advancing edge fetches the next location. This applies to single reads as well.
- R7: A start edge during a burst abandons every word of the old burst not yet fetched. A word fetched on the edge before the start edge still appears. After that, only the new access's words appear, on the R3/R5 schedule.
- R8: A write never raises `dataValid`. A write started during a burst also abandons that burst's unfetched words, as in R7.
- R9: No access yields more words than its kind allows: four for a burst, one for a single read, none for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new access on this edge |
| writeEn | input | 1 | With start: 1 = write, 0 = read |
| burstMode | input | 1 | With a read start: 1 = four-word burst, 0 = single word |
| advance | input | 1 | Allows the next read word to be fetched on this edge |
| addr | input | AW | Access address, sampled with start |
| dataIn | input | DW | Write data, sampled with a write start |
| dataOut | output | DW | Read data |
| dataValid | output | 1 | dataOut holds a read word this cycle |

## Verification
A start strobe can land on the very edge where the running burst would fetch its next word. That clash is forced by cutting a burst short after two or fewer fetches and starting a new access on the following edge, both as a read and as a write. The scoreboard judges it in two ways. The word fetched just before the clash must still arrive in its slot, and nothing from the abandoned part may follow. The new access's words must then arrive exactly on the R3/R5 cycles, which the monitor compares against a cycle stamp held with each expected word.

// File: rtl/burstSramPkg.sv
package burstSramPkg;
  // Strobes from the control section to the datapath for one edge.
  typedef struct packed {
    logic load;   // capture a read address into the beat counter
    logic write;  // store the write word
    logic issue;  // fetch the word at the counter and step it
  } ctlStrobe_t;
endpackage

// File: rtl/burstSramCtl.sv
module burstSramCtl
  import burstSramPkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       writeEn,
  input  logic       burstMode,
  input  logic       advance,
  output ctlStrobe_t strobe
);
  localparam int CW = $clog2(BEATS + 1);

  logic          active;
  logic [CW-1:0] beatsLeft;

  always_comb begin
    strobe.load  = start & ~writeEn;
    strobe.write = start & writeEn;
    // A start edge always wins over a pending fetch.
    strobe.issue = active & advance & ~start;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      beatsLeft <= '0;
    end else if (start) begin
      active    <= ~writeEn;
      beatsLeft <= burstMode ? CW'(BEATS) : CW'(1);
    end else if (strobe.issue) begin
      beatsLeft <= beatsLeft - 1'b1;
      active    <= (beatsLeft != CW'(1));
    end
  end
endmodule

// File: rtl/burstSramDp.sv
module burstSramDp
  import burstSramPkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataValid
);
  localparam int DEPTH = 1 << AW;
  localparam int WB    = $clog2(BEATS);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] beatAddr;
  logic [DW-1:0] fetchQ;
  logic          fetchValid;

  always_ff @(posedge clk) begin
    if (strobe.write) mem[addr] <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatAddr <= '0;
    end else if (strobe.load) begin
      beatAddr <= addr;
    end else if (strobe.issue) begin
      beatAddr <= {beatAddr[AW-1:WB], beatAddr[WB-1:0] + WB'(1)};
    end
  end

  // Stage one: array read. Stage two: output register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchQ     <= '0;
      fetchValid <= 1'b0;
      dataOut    <= '0;
      dataValid  <= 1'b0;
    end else begin
      fetchValid <= strobe.issue;
      if (strobe.issue) fetchQ <= mem[beatAddr];
      dataValid <= fetchValid;
      if (fetchValid) dataOut <= fetchQ;
    end
  end
endmodule

// File: rtl/burstSram.sv
module burstSram
  import burstSramPkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int BEATS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          writeEn,
  input  logic          burstMode,
  input  logic          advance,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] dataOut,
  output logic          dataValid
);
  ctlStrobe_t strobe;

  burstSramCtl #(.BEATS(BEATS)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .writeEn(writeEn),
    .burstMode(burstMode), .advance(advance), .strobe(strobe)
  );

  burstSramDp #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/burstSramChk.sv
module burstSramChk #(
  parameter int BEATS = 4
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic writeEn,
  input logic burstMode,
  input logic advance,
  input logic dataValid
);
  localparam int CW = $clog2(BEATS + 2);

  logic [CW-1:0] beatCnt;
  logic [CW-1:0] beatLimit;
  logic          startD1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt   <= '0;
      beatLimit <= '0;
      startD1   <= 1'b0;
    end else begin
      startD1 <= start;
      if (start) begin
        beatCnt   <= '0;
        beatLimit <= writeEn ? CW'(0) : (burstMode ? CW'(BEATS) : CW'(1));
      end else if (dataValid && !startD1) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  // R6
  adv_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> ##1 !dataValid);

  // R7
  start_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> ##1 !dataValid);

  // R8
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && writeEn) ##1 !start |=> ##1 !dataValid);

  // R9
  beat_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= beatLimit);
endmodule

bind burstSram burstSramChk #(.BEATS(BEATS)) u_chk (.*);

// File: tb/burstSram_tb.sv
module burstSram_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          writeEn = 1'b0;
  logic          burstMode = 1'b0;
  logic          advance = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataValid;

  burstSram #(.AW(AW), .DW(DW), .BEATS(4)) u_dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [DW-1:0] d;
    int            cyc;
    string         req;
  } expItem_t;

  expItem_t      expQ[$];
  logic [DW-1:0] model [256];
  int            cyc = 0;
  int            total = 0;
  int            bad = 0;
  bit            running = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every valid word must match the head of the queue, both in
  // value and in the cycle it arrives.
  always @(negedge clk) begin
    if (running && dataValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected word: got %h at cycle %0d, expected none", dataOut, cyc);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (dataOut !== e.d || cyc != e.cyc) begin
          bad++;
          $display("FAIL %s: got %h at cycle %0d, expected %h at cycle %0d",
                   e.req, dataOut, cyc, e.d, e.cyc);
        end
      end
    end
  end

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    start = 1'b1; writeEn = 1'b1; addr = a; dataIn = d;
    model[a] = d;
  endtask

  // Drives a read and pushes the expected words. Stops after maxBeats
  // fetches, holding advance low for stallLen edges before beat stallBeat.
  task automatic readOp(input logic [AW-1:0] a, input bit burst, input int maxBeats,
                        input int stallBeat, input int stallLen, input string req);
    int c;
    int b;
    int j;
    int stalled;
    @(negedge clk);
    start = 1'b1; writeEn = 1'b0; burstMode = burst; addr = a;
    c = cyc;
    b = 0; j = 1; stalled = 0;
    while (b < maxBeats) begin
      @(negedge clk);
      start = 1'b0;
      if (b == stallBeat && stalled < stallLen) begin
        advance = 1'b0;
        stalled++;
      end else begin
        logic [AW-1:0] ba;
        advance = 1'b1;
        ba = {a[AW-1:2], 2'(a[1:0] + 2'(b))};
        expQ.push_back('{model[ba], c + j + 2, req});
        b++;
      end
      j++;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    total++;
    if (dataValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 dataValid in reset: got %b expected 0", dataValid);
    end
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if (dataValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 dataValid after reset: got %b expected 0", dataValid);
    end
    running = 1'b1;

    for (int i = 0; i < 4; i++) begin
      doWrite(8'h40 + 8'(i), 16'hA000 + 16'(i));
      doWrite(8'h10 + 8'(i), 16'hB100 + 16'(i));
      doWrite(8'h80 + 8'(i), 16'hC200 + 16'(i));
    end

    // R3: plain 2-1-1-1 burst
    readOp(8'h40, 1'b1, 4, 9, 0, "R3 burst");
    // R4: wrap inside the aligned block
    readOp(8'h42, 1'b1, 4, 9, 0, "R4 wrap from 2");
    readOp(8'h13, 1'b1, 4, 9, 0, "R4 wrap from 3");
    // R5: back-to-back single reads
    readOp(8'h41, 1'b0, 1, 9, 0, "R5 single");
    readOp(8'h12, 1'b0, 1, 9, 0, "R5 single");
    readOp(8'h83, 1'b0, 1, 9, 0, "R5 single");
    // R6: suspend mid-burst, before the first word, and on a single read
    readOp(8'h80, 1'b1, 4, 2, 1, "R6 pause mid");
    readOp(8'h11, 1'b1, 4, 0, 3, "R6 pause first");
    readOp(8'h43, 1'b0, 1, 0, 2, "R6 pause single");
    // R7: abort a burst with a new read
    readOp(8'h81, 1'b1, 2, 9, 0, "R7 old part");
    readOp(8'h10, 1'b1, 4, 9, 0, "R7 new burst");
    // R2: write then read on the next edge
    doWrite(8'h55, 16'h1234);
    readOp(8'h55, 1'b0, 1, 9, 0, "R2 read after write");
    // R8: a write aborts a burst, then the block shows the new word
    readOp(8'h40, 1'b1, 1, 9, 0, "R8 old part");
    doWrite(8'h41, 16'h5A5A);
    readOp(8'h40, 1'b1, 4, 9, 0, "R8 after write");

    @(negedge clk);
    start = 1'b0; writeEn = 1'b0;
    repeat (6) @(negedge clk);
    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R9 missing words: got %0d left expected 0", expQ.size());
    end
    total++;
    if (dataValid !== 1'b0) begin
      bad++;
      $display("FAIL R9 idle dataValid: got %b expected 0", dataValid);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule